// File: doc/BRIEF.md
# HDLC Receive Line Condition Detector

This block sits on the receive side of a bit-oriented HDLC link. It accepts the recovered serial stream one bit at a time, qualified by a valid strobe. From that stream it reports three line conditions: the end of a flag pattern, an abort sequence and an idle line. It also follows the frame boundaries itself. When a frame closes, it checks whether the payload held a whole number of octets. Zero-bit deletion of the payload, CRC checking, FIFO storage and register access are left to neighbouring logic. This block only counts stuffed zeros out of its octet tally.

Every result is registered. A condition caused by a bit accepted at one clock edge becomes visible on the outputs just after that edge. Event outputs are high for exactly one clock. The idle level stays high for as long as the line stays idle. Clocks without a valid strobe leave all state untouched and produce no events.

Top module: `hdlc_line_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are low after that edge. The ones-run history is treated as all ones, so no flag can complete until a real 0 bit has been received.
- R2: `flag_evt` pulses for one clock after the accepted bit that completes the pattern 0,1,1,1,1,1,1,0 (in arrival order), whether or not a frame is open.
- R3: Inside a frame, the seventh consecutive accepted 1 raises `abort_evt` for one clock and drops `in_frame` at the same time. Longer runs of ones raise no further abort.
- R4: A run of seven or more ones that arrives outside a frame (after reset or after an abort) never raises `abort_evt`.
- R5: `idle_lvl` rises after the fifteenth consecutive accepted 1. It stays high through any further ones and falls after the next accepted 0.
- R6: `idle_evt` pulses for one clock together with the rise of `idle_lvl`, once per idle run.
- R7: After a flag, the next accepted bit that does not itself complete a flag sets `in_frame`. `in_frame` clears on a completed flag or on an abort.
- R8: When a flag closes a frame that held one or more payload bits, `nonoctet_evt` pulses together with `flag_evt` if the payload bit count is not a multiple of 8. A flag that closes an empty frame raises no `nonoctet_evt`.
- R9: A 0 bit that follows exactly five consecutive 1s inside a frame is a stuffed bit. It is excluded from the payload bit count.
- R10: A clock with `bit_vld` low changes no state: levels hold and no event pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Received bit is valid this clock |
| bit_in | input | 1 | Received serial bit |
| flag_evt | output | 1 | One-clock pulse: flag pattern completed |
| abort_evt | output | 1 | One-clock pulse: abort inside a frame |
| idle_evt | output | 1 | One-clock pulse: idle line began |
| idle_lvl | output | 1 | High while the line is idle |
| nonoctet_evt | output | 1 | One-clock pulse with a closing flag: payload not octet aligned |
| in_frame | output | 1 | Receiver is inside a frame |

## Verification
The hardest case to reach from the ports is a frame closed by a flag whose payload length modulo 8 depends on stuffed zeros being excluded. Only payload bytes with runs of five ones cause such zeros. The stimulus therefore uses payloads such as 0xFF and 0x7C followed by a closing flag. It also sends an 11-bit and a 1-bit payload, so both outcomes of the alignment check are exercised. A second hard case is an abort that starts partway through payload ones and then grows into an idle run. This is reached by sending a long run of ones directly after a payload that ends in 1s, so the abort lands before the run of sent ones is complete. One frame is also sent with two invalid clocks after every bit, to show that levels hold across gaps.

// File: rtl/hdlc_lcd_pkg.sv
`timescale 1ns/1ps
package hdlc_lcd_pkg;

    // A flag is a 0, this many ones, then a closing 0.
    localparam int FLAG_ONES  = 6;
    // Bits of a flag that precede its closing zero.
    localparam int FLAG_HEAD  = FLAG_ONES + 1;
    // A 0 after this many ones is a stuffed bit.
    localparam int STUFF_RUN  = FLAG_ONES - 1;
    localparam int OCTET_BITS = 8;
    localparam int OCT_W      = $clog2(OCTET_BITS);
    localparam int HIST_W     = FLAG_HEAD;

    // Arrival-ordered head of a flag; bit HIST_W-1 is the oldest.
    localparam logic [HIST_W-1:0] FLAG_HEAD_PAT = {1'b0, {FLAG_ONES{1'b1}}};

    // The payload count includes the flag head, so it is aligned when its
    // residue equals the residue of the head length.
    localparam logic [OCT_W-1:0] ALIGN_LOW = OCT_W'(FLAG_HEAD % OCTET_BITS);

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FRAME = 2'd2
    } frm_state_e;

    // Classification of the bit presented this clock.
    typedef struct packed {
        logic zero;
        logic flag_end;
        logic stuffed;
        logic abort_hit;
        logic idle_hit;
    } bit_class_t;

    // Payload counter: residue modulo an octet plus a sticky wrap marker.
    typedef struct packed {
        logic             wrapped;
        logic [OCT_W-1:0] low;
    } oct_cnt_t;

    function automatic oct_cnt_t oct_step(input oct_cnt_t c);
        oct_cnt_t r;
        r.low     = c.low + 1'b1;
        r.wrapped = c.wrapped | (c.low == OCT_W'(OCTET_BITS - 1));
        return r;
    endfunction

endpackage

// File: rtl/hdlc_run_counter.sv
`timescale 1ns/1ps
module hdlc_run_counter
    import hdlc_lcd_pkg::*;
#(
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    output bit_class_t cls
);

    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX    = RUN_W'(IDLE_RUN);
    localparam logic [RUN_W-1:0] ABORT_PRE  = RUN_W'(ABORT_RUN - 1);
    localparam logic [RUN_W-1:0] IDLE_PRE   = RUN_W'(IDLE_RUN - 1);
    localparam logic [RUN_W-1:0] STUFF_PRE  = RUN_W'(STUFF_RUN);

    logic [RUN_W-1:0]  run_q;
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            hist_q <= '1;
        end else if (bit_vld) begin
            if (!bit_in)
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    always_comb begin
        cls.zero      = !bit_in;
        cls.flag_end  = !bit_in && (hist_q == FLAG_HEAD_PAT);
        cls.stuffed   = !bit_in && (run_q == STUFF_PRE);
        cls.abort_hit = bit_in && (run_q == ABORT_PRE);
        cls.idle_hit  = bit_in && (run_q == IDLE_PRE);
    end

    assert_run_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(run_q) && $stable(hist_q));

    assert_run_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !bit_in) |=> (run_q == '0));

endmodule

// File: rtl/hdlc_frame_tracker.sv
`timescale 1ns/1ps
module hdlc_frame_tracker
    import hdlc_lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  bit_class_t cls,
    output logic       flag_evt,
    output logic       abort_evt,
    output logic       nonoctet_evt,
    output logic       in_frame
);

    frm_state_e st_q, st_d;
    oct_cnt_t   cnt_q, cnt_d;
    logic       flag_q, flag_d;
    logic       abort_q, abort_d;
    logic       nonoct_q, nonoct_d;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        flag_d   = 1'b0;
        abort_d  = 1'b0;
        nonoct_d = 1'b0;
        if (bit_vld) begin
            if (cls.flag_end) begin
                flag_d = 1'b1;
                if (st_q == ST_FRAME)
                    nonoct_d = cnt_q.wrapped && (cnt_q.low != ALIGN_LOW);
                st_d  = ST_OPEN;
                cnt_d = '0;
            end else begin
                unique case (st_q)
                    ST_OPEN: begin
                        st_d  = ST_FRAME;
                        cnt_d = '{wrapped: 1'b0, low: OCT_W'(1)};
                    end
                    ST_FRAME: begin
                        if (cls.abort_hit) begin
                            abort_d = 1'b1;
                            st_d    = ST_HUNT;
                            cnt_d   = '0;
                        end else if (!cls.stuffed) begin
                            cnt_d = oct_step(cnt_q);
                        end
                    end
                    default: begin
                        st_d = ST_HUNT;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_HUNT;
            cnt_q    <= '0;
            flag_q   <= 1'b0;
            abort_q  <= 1'b0;
            nonoct_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            flag_q   <= flag_d;
            abort_q  <= abort_d;
            nonoct_q <= nonoct_d;
        end
    end

    assign flag_evt     = flag_q;
    assign abort_evt    = abort_q;
    assign nonoctet_evt = nonoct_q;
    assign in_frame     = (st_q == ST_FRAME);

    assert_abort_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && cls.abort_hit && st_q != ST_FRAME) |=> !abort_q);

    assert_abort_exits_R3: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> (st_q == ST_HUNT));

    assert_flag_single_R2: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> !flag_q);

    assert_nonoct_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
        nonoct_q |-> flag_q);

    assert_flag_not_abort_R2: assert property (@(posedge clk) disable iff (rst)
        !(flag_q && abort_q));

    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(st_q) && $stable(cnt_q) && !flag_q && !abort_q);

endmodule

// File: rtl/hdlc_idle_tracker.sv
`timescale 1ns/1ps
module hdlc_idle_tracker
    import hdlc_lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  bit_class_t cls,
    output logic       idle_lvl,
    output logic       idle_evt
);

    logic lvl_q;
    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (bit_vld) begin
                if (cls.idle_hit) begin
                    lvl_q <= 1'b1;
                    evt_q <= 1'b1;
                end else if (cls.zero) begin
                    lvl_q <= 1'b0;
                end
            end
        end
    end

    assign idle_lvl = lvl_q;
    assign idle_evt = evt_q;

    assert_idle_evt_rise_R6: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> (lvl_q && !$past(lvl_q)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (lvl_q && !(bit_vld && cls.zero)) |=> lvl_q);

    assert_idle_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && cls.zero) |=> !lvl_q);

endmodule

// File: rtl/hdlc_line_monitor.sv
`timescale 1ns/1ps
module hdlc_line_monitor
    import hdlc_lcd_pkg::*;
#(
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic flag_evt,
    output logic abort_evt,
    output logic idle_evt,
    output logic idle_lvl,
    output logic nonoctet_evt,
    output logic in_frame
);

    bit_class_t cls;

    hdlc_run_counter #(
        .ABORT_RUN (ABORT_RUN),
        .IDLE_RUN  (IDLE_RUN)
    ) run_i (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .cls     (cls)
    );

    hdlc_frame_tracker frame_i (
        .clk          (clk),
        .rst          (rst),
        .bit_vld      (bit_vld),
        .cls          (cls),
        .flag_evt     (flag_evt),
        .abort_evt    (abort_evt),
        .nonoctet_evt (nonoctet_evt),
        .in_frame     (in_frame)
    );

    hdlc_idle_tracker idle_i (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .cls      (cls),
        .idle_lvl (idle_lvl),
        .idle_evt (idle_evt)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !flag_evt && !abort_evt && !idle_evt && !idle_lvl && !nonoctet_evt && !in_frame);

endmodule

// File: tb/hdlc_line_monitor_tb_top.sv
`timescale 1ns/1ps
module hdlc_line_monitor_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic flag_evt, abort_evt, idle_evt, idle_lvl, nonoctet_evt, in_frame;

    always #2 clk = ~clk;

    hdlc_line_monitor dut_i (
        .clk          (clk),
        .rst          (rst),
        .bit_vld      (bit_vld),
        .bit_in       (bit_in),
        .flag_evt     (flag_evt),
        .abort_evt    (abort_evt),
        .idle_evt     (idle_evt),
        .idle_lvl     (idle_lvl),
        .nonoctet_evt (nonoctet_evt),
        .in_frame     (in_frame)
    );

    typedef struct {
        logic [5:0] e;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench-side expectation state, built from the requirements.
    int    run_m = 0;
    logic  idle_m = 1'b0;
    int    st_m = 0;          // 0 hunt, 1 after flag, 2 in frame
    int    data_m = 0;
    int    tx_ones = 0;
    int    gap_n = 0;
    string cur_tag = "R1";

    // Field order: flag R2, abort R3, idle_evt R6, nonoct R8, idle_lvl R5, in_frame R7
    function automatic string fname(input int i);
        case (i)
            5: return "R2 flag_evt";
            4: return "R3 abort_evt";
            3: return "R6 idle_evt";
            2: return "R8 nonoctet_evt";
            1: return "R5 idle_lvl";
            default: return "R7 in_frame";
        endcase
    endfunction

    task automatic push(input logic v, input logic b, input logic f, input logic no);
        logic a, ie;
        item_t it;
        a = 1'b0;
        ie = 1'b0;
        @(negedge clk);
        bit_vld = v;
        bit_in = b;
        if (v) begin
            if (b) begin
                run_m++;
                if (run_m == 7 && st_m == 2) a = 1'b1;
                if (run_m == 15) ie = 1'b1;
            end else begin
                run_m = 0;
                idle_m = 1'b0;
            end
            if (ie) idle_m = 1'b1;
            if (f) st_m = 1;
            else if (a) st_m = 0;
            else if (st_m == 1) st_m = 2;
        end
        it.e = {v & f, a, ie, v & no, idle_m, (st_m == 2)};
        it.tag = (v == 1'b0) ? "R10" : cur_tag;
        q.push_back(it);
    endtask

    task automatic send_bit(input logic b, input logic f, input logic no);
        push(1'b1, b, f, no);
        for (int g = 0; g < gap_n; g++) push(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_flag();
        logic no;
        tx_ones = 0;
        send_bit(1'b0, 1'b0, 1'b0);
        send_ones(6);
        no = (st_m == 2) && (data_m > 0) && (data_m % 8 != 0);
        send_bit(1'b0, 1'b1, no);
        data_m = 0;
        tx_ones = 0;
    endtask

    // LSB first, with transmitter zero insertion after five ones (R9).
    task automatic send_data(input logic [15:0] val, input int n);
        for (int i = 0; i < n; i++) begin
            send_bit(val[i], 1'b0, 1'b0);
            data_m++;
            if (val[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    send_bit(1'b0, 1'b0, 1'b0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
    endtask

    // Monitor: compares each result just after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it = q.pop_front();
                act = {flag_evt, abort_evt, idle_evt, nonoctet_evt, idle_lvl, in_frame};
                for (int i = 5; i >= 0; i--) begin
                    checks++;
                    if (act[i] !== it.e[i]) begin
                        failures++;
                        $display("FAIL %s (context %s) act=%0b exp=%0b t=%0t",
                                 fname(i), it.tag, act[i], it.e[i], $time);
                    end
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        checks++;
        if ({flag_evt, abort_evt, idle_evt, nonoctet_evt, idle_lvl, in_frame} !== 6'b0) begin
            failures++;
            $display("FAIL R1 reset outputs act=%b exp=000000",
                     {flag_evt, abort_evt, idle_evt, nonoctet_evt, idle_lvl, in_frame});
        end
        rst = 1'b0;

        // R4/R5/R6: ones after reset: idle but no abort
        cur_tag = "R4";
        send_ones(20);
        cur_tag = "R5";
        send_bit(1'b0, 1'b0, 1'b0);

        // R2/R7: aligned single-octet frame
        cur_tag = "R2";
        send_flag();
        cur_tag = "R7";
        send_data(16'h00A5, 8);
        send_flag();

        // R9: stuffed zeros excluded, still aligned
        cur_tag = "R9";
        send_data(16'h7CFF, 16);
        send_flag();

        // R8: 11-bit payload is non-octet
        cur_tag = "R8";
        send_data(16'h035A, 11);
        send_flag();

        // R8: empty frame between two flags: no non-octet
        send_flag();

        // R10: frame with invalid clocks between bits
        cur_tag = "R10";
        gap_n = 2;
        send_data(16'h003C, 8);
        send_flag();
        gap_n = 0;

        // R3: abort inside a frame, then long run reaches idle (R4: no second abort)
        cur_tag = "R3";
        send_data(16'h00C3, 8);
        send_ones(20);
        cur_tag = "R10";
        gap_n = 3;
        send_ones(2);
        gap_n = 0;
        cur_tag = "R5";
        send_bit(1'b0, 1'b0, 1'b0);

        // R8: one-bit payload
        cur_tag = "R8";
        send_flag();
        send_data(16'h0001, 1);
        send_flag();

        push(1'b0, 1'b0, 1'b0, 1'b0);
        push(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule